// File: doc/BRIEF.md
# Pulse Width Window Checker

This block watches a stream of positive pulses on a single asynchronous input and reports every pulse whose width lies outside an acceptable window. The input passes through a two-flop synchronizer and its width is then measured in system clock cycles. Two runtime limits, a lower and an upper width bound, set the window. Every pulse outside the window produces exactly one single-cycle fault pulse. One of two cause flags is raised in the same cycle to tell a short pulse from a long one.

When a pulse rises, two independent timers start together. The lower-bound timer decides, on the falling edge, whether the pulse ended too early. The upper-bound timer fires the moment the pulse outlasts the upper bound, so a long pulse is reported while it is still high. It is not reported again when it finally falls. A merge stage gates the two results into the single fault output.

Top module: `pwidth_window_chk`

## Requirements
- R1: After a synchronous active-low reset, `fault`, `too_short` and `too_long` are all 0.
- R2: A pulse whose width w (the number of rising clock edges that sample `pulse_in` high) satisfies `lo_width` <= w <= `hi_width` produces no fault. Both bounds count as acceptable.
- R3: A pulse with w < `lo_width` and w <= `hi_width` gives one fault cycle with `too_short`=1. It appears at the edge two cycles after the first edge that samples `pulse_in` low.
- R4: A pulse with w > `hi_width` gives one fault cycle with `too_long`=1. It appears at edge t+`hi_width`+2, where t is the first edge that samples `pulse_in` high. The later falling edge of the same pulse gives no second fault.
- R5: `fault` is high for exactly one cycle per out-of-range pulse. `too_short` or `too_long` is 1 only in a cycle where `fault` is 1, and exactly one of them is 1 in that cycle.
- R6: When `lo_width` > `hi_width`, every pulse gives exactly one fault. A pulse that is both too short and too long is reported as `too_long`.
- R7: Pulses separated by a single low sample are measured independently. Each width starts counting afresh.
- R8: `pulse_in` passes through two synchronizing flops before it is measured. This sets the fixed delays stated in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse train to check |
| lo_width | input | W | Minimum acceptable width in clock cycles |
| hi_width | input | W | Maximum acceptable width in clock cycles |
| fault | output | 1 | One-cycle pulse for each out-of-range input pulse |
| too_short | output | 1 | Cause flag: the pulse ended before the minimum |
| too_long | output | 1 | Cause flag: the pulse outlasted the maximum |

## Verification
Every combination of lower and upper bound from 0 to 6 is tried with every pulse width from 1 to 9. This places widths below, on, inside, on, and above each bound, and with the bounds inverted, so the inclusive edges of the window and the long-over-short priority are told apart. Each sweep runs twice. With wide gaps between pulses, the pulses are measured in isolation. With a single low sample between pulses, a missing counter clear or a stale long-pulse memory would show up in the next pulse. Every fault is matched to its exact expected edge and cause, which checks the synchronizer delay and shows that a long pulse is reported only once.

// File: rtl/pwc_pkg.sv
// Shared types for the pulse width window checker.
package pwc_pkg;
    // Which end of the window a timer guards.
    typedef enum logic {
        BOUND_LO = 1'b0,
        BOUND_HI = 1'b1
    } pwc_bound_e;
endpackage

// File: rtl/pwc_sync.sv
// Two-flop synchronizer for the asynchronous pulse input.
// Assumes: pulse_in may change at any time; the output is the level seen
// two clock edges later.
module pwc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic lvl
);
    logic stage1;
    logic stage2;

    // Move the input through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
        end else begin
            stage1 <= pulse_in;
            stage2 <= stage1;
        end
    end

    assign lvl = stage2;
endmodule

// File: rtl/pwc_timer.sv
// Width timer started by the leading edge of a synchronized pulse.
// It counts high cycles. BOUND selects the variant:
//   BOUND_LO: hit = the pulse ended with fewer than `limit` high cycles.
//   BOUND_HI: hit = one cycle when the pulse is `limit`+1 cycles long.
// Assumes: lvl is synchronous; the counter has one spare bit, so it
// saturates above any legal limit and the HI hit cannot repeat.
module pwc_timer
    import pwc_pkg::*;
#(
    parameter int         W     = 8,
    parameter pwc_bound_e BOUND = BOUND_LO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lvl,
    input  logic [W-1:0] limit,
    output logic         hit
);
    localparam int CW = W + 1;
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_x;

    assign lim_x = {1'b0, limit};

    // Count high cycles of the current pulse; clear while the input is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!lvl) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (BOUND == BOUND_LO) begin : g_lo
            // Falling cycle: the count holds the full width of the pulse.
            assign hit = !lvl && (cnt_q != '0) && (cnt_q < lim_x);
        end else begin : g_hi
            // The current cycle makes the width exceed the limit.
            assign hit = lvl && (cnt_q == lim_x);
        end
    endgenerate

    // R7: the count starts afresh after any low cycle.
    assert_count_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl |=> (cnt_q == '0));

    // R4: the upper-bound hit fires once per pulse.
    assert_hit_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (BOUND == BOUND_HI && hit) |=> !hit);
endmodule

// File: rtl/pwc_merge.sv
// Merges the lower- and upper-bound timer results into one registered fault
// pulse and two cause flags. After an upper-bound hit, the short result at
// the same pulse's falling edge is suppressed, so the long cause wins.
// Assumes: both hits are single-cycle and never occur in the same cycle.
module pwc_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic short_hit,
    input  logic long_hit,
    output logic fault,
    output logic too_short,
    output logic too_long
);
    logic long_seen;
    logic short_ok;

    assign short_ok = short_hit && !long_seen;

    // Remember that the current pulse was already reported as long.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_seen <= 1'b0;
        end else if (!lvl) begin
            long_seen <= 1'b0;
        end else if (long_hit) begin
            long_seen <= 1'b1;
        end
    end

    // Register the merged fault pulse and its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault     <= 1'b0;
            too_short <= 1'b0;
            too_long  <= 1'b0;
        end else begin
            fault     <= short_ok || long_hit;
            too_short <= short_ok;
            too_long  <= long_hit;
        end
    end

    // R5: the fault pulse is one cycle wide.
    assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R5: a cause flag appears only together with the fault pulse.
    assert_flag_with_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (too_short || too_long) |-> fault);

    // R6: the two causes are never reported together.
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(too_short && too_long));
endmodule

// File: rtl/pwidth_window_chk.sv
// Pulse width window checker, top level.
// It synchronizes pulse_in, starts the lower- and upper-bound timers together
// on each leading edge, and merges their results into a single fault pulse.
// Assumes: lo_width and hi_width are held steady while a pulse is measured.
module pwidth_window_chk
    import pwc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pulse_in,
    input  logic [W-1:0] lo_width,
    input  logic [W-1:0] hi_width,
    output logic         fault,
    output logic         too_short,
    output logic         too_long
);
    localparam int NT = 2;

    logic           lvl;
    logic [NT-1:0]  hits;
    logic [W-1:0]   limits [NT];

    assign limits[0] = lo_width;
    assign limits[1] = hi_width;

    pwc_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (pulse_in),
        .lvl      (lvl)
    );

    generate
        for (genvar i = 0; i < NT; i++) begin : g_tmr
            pwc_timer #(
                .W     (W),
                .BOUND ((i == 0) ? BOUND_LO : BOUND_HI)
            ) u_tmr (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (lvl),
                .limit (limits[i]),
                .hit   (hits[i])
            );
        end
    endgenerate

    pwc_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .short_hit (hits[0]),
        .long_hit  (hits[1]),
        .fault     (fault),
        .too_short (too_short),
        .too_long  (too_long)
    );

    // R8: a fault can only follow a synchronized change of the input.
    assert_fault_after_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> ($past(lvl) != $past(lvl, 2)) || $past(lvl));
endmodule

// File: tb/sim_pwidth_window_chk.sv
// Sweep bench: every bound pair 0..6 and width 1..9, with two gap lengths.
// Expected faults are queued with their exact edge number and cause.
module sim_pwidth_window_chk;
    localparam int W    = 8;
    localparam int QD   = 2048;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pulse_in = 1'b0;
    logic [W-1:0] lo_width = '0;
    logic [W-1:0] hi_width = '0;
    logic         fault, too_short, too_long;

    int checks = 0;
    int errors = 0;
    int edge_cnt = 0;
    bit done = 1'b0;

    int exp_edge [QD];
    bit exp_long [QD];
    bit exp_inv  [QD];
    int wr = 0;
    int rd = 0;

    pwidth_window_chk #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
        .lo_width(lo_width), .hi_width(hi_width),
        .fault(fault), .too_short(too_short), .too_long(too_long)
    );

    always #4 clk = ~clk;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    // Compare every sampled output with the expected event queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fault) begin
                checks++;
                if (rd >= wr || exp_edge[rd] != edge_cnt) begin
                    errors++;
                    $display("FAIL R2 unexpected fault at edge %0d: got fault=1 expected 0 (next expected edge %0d)",
                             edge_cnt, (rd < wr) ? exp_edge[rd] : -1);
                end else begin
                    if (too_long != exp_long[rd] || too_short != !exp_long[rd]) begin
                        errors++;
                        if (exp_inv[rd])
                            $display("FAIL R6 cause at edge %0d: got short=%0b long=%0b expected long=%0b",
                                     edge_cnt, too_short, too_long, exp_long[rd]);
                        else
                            $display("FAIL R5 cause at edge %0d: got short=%0b long=%0b expected long=%0b",
                                     edge_cnt, too_short, too_long, exp_long[rd]);
                    end
                    rd++;
                end
            end else begin
                if (too_short || too_long) begin
                    checks++;
                    errors++;
                    $display("FAIL R5 flag without fault at edge %0d: got short=%0b long=%0b expected 0 0",
                             edge_cnt, too_short, too_long);
                end
                if (rd < wr && exp_edge[rd] == edge_cnt) begin
                    checks++;
                    errors++;
                    if (exp_long[rd])
                        $display("FAIL R4 missing long fault at edge %0d: got 0 expected 1", edge_cnt);
                    else
                        $display("FAIL R3 missing short fault at edge %0d: got 0 expected 1", edge_cnt);
                    rd++;
                end
            end
        end
    end

    // Drive one pulse of w samples and queue the expected outcome.
    task automatic send_pulse(input int w, input int gap);
        int t;
        int lo;
        int hi;
        lo = int'(lo_width);
        hi = int'(hi_width);
        @(posedge clk);
        #1;
        pulse_in = 1'b1;
        t = edge_cnt + 1;
        if (w > hi) begin
            exp_edge[wr] = t + hi + 2;      // R4 and, when lo > hi, R6
            exp_long[wr] = 1'b1;
            exp_inv[wr]  = (lo > hi);
            wr++;
        end else if (w < lo) begin
            exp_edge[wr] = t + w + 2;       // R3
            exp_long[wr] = 1'b0;
            exp_inv[wr]  = 1'b0;
            wr++;
        end
        repeat (w) @(posedge clk);
        #1;
        pulse_in = 1'b0;
        repeat (gap - 1) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;                            // R1
        if (fault || too_short || too_long) begin
            errors++;
            $display("FAIL R1 reset outputs: got %0b%0b%0b expected 000", fault, too_short, too_long);
        end
        for (int g = 0; g < 2; g++) begin
            for (int lo = 0; lo <= 6; lo++) begin
                for (int hi = 0; hi <= 6; hi++) begin
                    @(posedge clk);
                    #1;
                    lo_width = W'(lo);
                    hi_width = W'(hi);
                    for (int w = 1; w <= 9; w++) begin
                        send_pulse(w, (g == 0) ? 6 : 1);   // R7 on g==1
                    end
                    repeat (12) @(posedge clk);
                end
            end
        end
        repeat (12) @(posedge clk);
        @(negedge clk);
        checks++;                            // R2 / R3 / R4: every expected fault seen
        if (rd != wr) begin
            errors++;
            $display("FAIL R4 unmatched expected faults: got %0d expected %0d", rd, wr);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule